// File: doc/BRIEF.md
# Segmented Hashed Address Translator

This block turns a 32-bit process address into a 32-bit physical address. The top four address bits select one of sixteen segment registers. The selected register supplies a 24-bit extension, and that extension, placed above the 16-bit page field, forms a 40-bit global page number. The block hashes the global page number to a bucket index and searches at most two buckets of an internal hashed page table: first the primary bucket, then its complement. Each bucket holds four entries, and each entry carries a valid flag, the full 40-bit tag and a 20-bit physical page number.

The first entry that matches supplies the physical page. That page number is placed above the unchanged 12-bit byte offset. If no entry in either bucket matches, the block reports a page fault so that system software can refill the table through the entry write port and retry. Requests use a valid/ready handshake, and only one request is in flight at a time. Each result appears as a one-cycle response pulse.

Top module: `xlat_top`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0, every segment register holds 0 and every table entry is invalid, so the first lookup faults.
- R2: The global page number of a request is {segment register[addr[31:28]], addr[27:12]}, 40 bits. The segment register value is taken at the accepting edge.
- R3: The primary bucket index is the low 6 bits of (segment register value XOR the zero-extended page field). The secondary index is the bitwise complement of the primary index.
- R4: A valid entry in the primary bucket whose tag equals the global page number gives rsp_fault_o=0 and rsp_paddr_o={ppn, addr[11:0]}. rsp_valid_o is high in the cycle that follows the second rising edge counted from the edge before acceptance: two edges after the request is driven.
- R5: When only the secondary bucket matches, the result has the same form as in R4 and appears one cycle later: three edges after the request is driven.
- R6: When neither bucket matches, the response appears three edges after the request is driven, with rsp_fault_o=1 and rsp_paddr_o=0.
- R7: The primary bucket takes priority over the secondary bucket. Within a bucket, the lowest-numbered matching way wins.
- R8: After a request is accepted, req_ready_o stays low until the response cycle has ended. rsp_valid_o is never high for two cycles in a row.
- R9: Writing an entry with tbl_valid_i=0 removes it, so a later lookup of that page faults.
- R10: Segment register writes and table writes (bucket, way) apply to every lookup accepted after the write, including overwriting an entry's physical page.
- R11: A hit needs all 40 tag bits to match. An entry that differs only in the upper segment bits does not hit, even though it lands in the same bucket.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block idle and able to accept a request |
| req_addr_i | input | 32 | Process address to translate |
| seg_we_i | input | 1 | Segment register write enable |
| seg_sel_i | input | 4 | Segment register selected for write |
| seg_data_i | input | 24 | Segment extension written |
| tbl_we_i | input | 1 | Table entry write enable |
| tbl_bucket_i | input | 6 | Bucket of the entry written |
| tbl_way_i | input | 2 | Way of the entry written |
| tbl_valid_i | input | 1 | Valid flag written (0 invalidates) |
| tbl_gpn_i | input | 40 | Global page number tag written |
| tbl_ppn_i | input | 20 | Physical page number written |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_fault_o | output | 1 | Page fault: no entry matched in either bucket |
| rsp_paddr_o | output | 32 | Translated physical address (0 on fault) |

## Verification
The assertions assume that requests are offered only through the handshake. They also assume that the byte offset reported in a hit is the one captured at acceptance, which holds only if the address is not re-driven in a way that the block ignores. The stimulus never writes segment registers or table entries while a lookup is in flight. That keeps the expected result of each lookup fixed by the writes made before it. The driver waits for req_ready_o and for the scoreboard queue to drain before it issues the next request, so that the response timing and the ordering against writes stay as the requirements state them.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  parameter int VA_W   = 32;
  parameter int SNUM_W = 4;
  parameter int PAGE_W = 16;
  parameter int OFF_W  = 12;
  parameter int SEG_W  = 24;
  parameter int PPN_W  = 20;
  parameter int NBKT   = 64;
  parameter int WAYS   = 4;
  localparam int GPN_W = SEG_W + PAGE_W;
  localparam int IDX_W = $clog2(NBKT);
  localparam int WAY_W = $clog2(WAYS);
  localparam int NSEG  = 1 << SNUM_W;

  typedef struct packed {
    logic             vld;
    logic [GPN_W-1:0] tag;
    logic [PPN_W-1:0] ppn;
  } xlat_entry_t;

  typedef enum logic [1:0] {ST_IDLE, ST_PRI, ST_SEC, ST_RESP} xlat_state_e;
endpackage

// File: rtl/xlat_seg_file.sv
module xlat_seg_file
  import xlat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SNUM_W-1:0] wsel_i,
  input  logic [SEG_W-1:0]  wdata_i,
  input  logic [SNUM_W-1:0] rsel_i,
  output logic [SEG_W-1:0]  rdata_o
);
  logic [SEG_W-1:0] seg_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 seg_q[g] <= '0;
      else if (we_i && wsel_i == SNUM_W'(g))       seg_q[g] <= wdata_i;
    end
  end

  assign rdata_o = seg_q[rsel_i];
endmodule

// File: rtl/xlat_bucket_mem.sv
module xlat_bucket_mem
  import xlat_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       wbkt_i,
  input  logic [WAY_W-1:0]       wway_i,
  input  xlat_entry_t            wentry_i,
  input  logic [IDX_W-1:0]       rbkt_i,
  output xlat_entry_t [WAYS-1:0] rbucket_o
);
  xlat_entry_t [WAYS-1:0] mem_q [NBKT];

  for (genvar b = 0; b < NBKT; b++) begin : g_bkt
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          mem_q[b][w] <= '0;
        else if (we_i && wbkt_i == IDX_W'(b) && wway_i == WAY_W'(w))
          mem_q[b][w] <= wentry_i;
      end
    end
  end

  assign rbucket_o = mem_q[rbkt_i];
endmodule

// File: rtl/xlat_way_cmp.sv
module xlat_way_cmp
  import xlat_pkg::*;
(
  input  logic [GPN_W-1:0]       key_i,
  input  xlat_entry_t [WAYS-1:0] bucket_i,
  output logic                   hit_o,
  output logic [PPN_W-1:0]       ppn_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = bucket_i[w].vld && (bucket_i[w].tag == key_i);
  end

  // lowest matching way wins
  always_comb begin
    ppn_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) ppn_o = bucket_i[w].ppn;
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/xlat_top.sv
module xlat_top
  import xlat_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [VA_W-1:0]        req_addr_i,
  input  logic                   seg_we_i,
  input  logic [SNUM_W-1:0]      seg_sel_i,
  input  logic [SEG_W-1:0]       seg_data_i,
  input  logic                   tbl_we_i,
  input  logic [IDX_W-1:0]       tbl_bucket_i,
  input  logic [WAY_W-1:0]       tbl_way_i,
  input  logic                   tbl_valid_i,
  input  logic [GPN_W-1:0]       tbl_gpn_i,
  input  logic [PPN_W-1:0]       tbl_ppn_i,
  output logic                   rsp_valid_o,
  output logic                   rsp_fault_o,
  output logic [VA_W-1:0]        rsp_paddr_o
);
  localparam int PAGE_LO = OFF_W;
  localparam int SNUM_LO = OFF_W + PAGE_W;

  xlat_state_e             state_q;
  logic [GPN_W-1:0]        key_q;
  logic [OFF_W-1:0]        off_q;
  logic [IDX_W-1:0]        pidx_q;
  logic [PPN_W-1:0]        ppn_q;
  logic                    fault_q;

  logic [SEG_W-1:0]        seg_rd;
  logic [PAGE_W-1:0]       page;
  logic [SEG_W-1:0]        hash;
  logic [IDX_W-1:0]        rd_idx;
  xlat_entry_t [WAYS-1:0]  bucket;
  xlat_entry_t             wentry;
  logic                    hit;
  logic [PPN_W-1:0]        hit_ppn;
  logic                    accept;

  assign page   = req_addr_i[SNUM_LO-1:PAGE_LO];
  assign hash   = seg_rd ^ {{(SEG_W-PAGE_W){1'b0}}, page};
  assign accept = req_valid_i && req_ready_o;
  assign rd_idx = (state_q == ST_SEC) ? ~pidx_q : pidx_q;
  assign wentry = '{vld: tbl_valid_i, tag: tbl_gpn_i, ppn: tbl_ppn_i};

  xlat_seg_file u_seg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (seg_we_i),
    .wsel_i  (seg_sel_i),
    .wdata_i (seg_data_i),
    .rsel_i  (req_addr_i[VA_W-1:SNUM_LO]),
    .rdata_o (seg_rd)
  );

  xlat_bucket_mem u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (tbl_we_i),
    .wbkt_i    (tbl_bucket_i),
    .wway_i    (tbl_way_i),
    .wentry_i  (wentry),
    .rbkt_i    (rd_idx),
    .rbucket_o (bucket)
  );

  xlat_way_cmp u_cmp (
    .key_i    (key_q),
    .bucket_i (bucket),
    .hit_o    (hit),
    .ppn_o    (hit_ppn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      key_q   <= '0;
      off_q   <= '0;
      pidx_q  <= '0;
      ppn_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          key_q   <= {seg_rd, page};
          off_q   <= req_addr_i[OFF_W-1:0];
          pidx_q  <= hash[IDX_W-1:0];
          state_q <= ST_PRI;
        end
        ST_PRI: if (hit) begin
          ppn_q   <= hit_ppn;
          fault_q <= 1'b0;
          state_q <= ST_RESP;
        end else begin
          state_q <= ST_SEC;
        end
        ST_SEC: begin
          ppn_q   <= hit ? hit_ppn : '0;
          fault_q <= !hit;
          state_q <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_fault_o = rsp_valid_o && fault_q;
  assign rsp_paddr_o = (rsp_valid_o && !fault_q) ? {ppn_q, off_q} : '0;
endmodule

// File: rtl/xlat_checker.sv
module xlat_checker
  import xlat_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [VA_W-1:0] req_addr_i,
  input logic            rsp_valid_o,
  input logic            rsp_fault_o,
  input logic [VA_W-1:0] rsp_paddr_o
);
  logic             acc;
  logic [OFF_W-1:0] off_seen;

  assign acc = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  off_seen <= '0;
    else if (acc) off_seen <= req_addr_i[OFF_W-1:0];
  end

  AST_RSP_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !req_ready_o && !rsp_valid_o); // R8
  AST_NOT_READY_IN_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o); // R8
  AST_FAULT_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_paddr_o == '0)); // R6
  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_paddr_o[OFF_W-1:0] == off_seen)); // R4
  AST_FAULT_ONLY_IN_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_valid_o); // R6
endmodule

bind xlat_top xlat_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_fault_o (rsp_fault_o),
  .rsp_paddr_o (rsp_paddr_o)
);

// File: tb/tb_xlat_top.sv
module tb_xlat_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic        seg_we_i = 1'b0;
  logic [3:0]  seg_sel_i = '0;
  logic [23:0] seg_data_i = '0;
  logic        tbl_we_i = 1'b0;
  logic [5:0]  tbl_bucket_i = '0;
  logic [1:0]  tbl_way_i = '0;
  logic        tbl_valid_i = 1'b0;
  logic [39:0] tbl_gpn_i = '0;
  logic [19:0] tbl_ppn_i = '0;
  logic        rsp_valid_o;
  logic        rsp_fault_o;
  logic [31:0] rsp_paddr_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  logic [31:0] exp_pa[$];
  logic        exp_f[$];
  int          exp_t[$];
  string       exp_r[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  xlat_top dut (.*);

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [5:0] pidx(input logic [23:0] seg, input logic [15:0] pg);
    return seg[5:0] ^ pg[5:0];
  endfunction

  task automatic seg_wr(input logic [3:0] sel, input logic [23:0] val);
    @(negedge clk_i);
    seg_we_i = 1'b1; seg_sel_i = sel; seg_data_i = val;
    @(negedge clk_i);
    seg_we_i = 1'b0;
  endtask

  task automatic tbl_wr(input logic [5:0] bkt, input logic [1:0] way, input logic v,
                        input logic [39:0] gpn, input logic [19:0] ppn);
    @(negedge clk_i);
    tbl_we_i = 1'b1; tbl_bucket_i = bkt; tbl_way_i = way;
    tbl_valid_i = v; tbl_gpn_i = gpn; tbl_ppn_i = ppn;
    @(negedge clk_i);
    tbl_we_i = 1'b0;
  endtask

  // driver: push expected item, issue request, wait for drain
  task automatic lookup(input logic [31:0] addr, input logic [31:0] pa, input logic f,
                        input int lat, input string rq);
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    exp_pa.push_back(pa); exp_f.push_back(f);
    exp_t.push_back(cyc + lat); exp_r.push_back(rq);
    req_valid_i = 1'b1; req_addr_i = addr;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    while (exp_pa.size() != 0) @(negedge clk_i);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && rsp_valid_o) begin
      if (exp_pa.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8 actual=unexpected response expected=none");
      end else begin
        automatic string rq = exp_r.pop_front();
        automatic logic [31:0] pa = exp_pa.pop_front();
        automatic logic f = exp_f.pop_front();
        automatic int t = exp_t.pop_front();
        chk({rq, " paddr"}, rsp_paddr_o, pa);
        chk({rq, " fault"}, {31'b0, rsp_fault_o}, {31'b0, f});
        chk({rq, " latency"}, cyc, t);
        chk("R8 ready low in response", {31'b0, req_ready_o}, 32'd0);
      end
    end
  end

  // watchdog
  always @(posedge clk_i) begin
    if (cyc >= WDOG_LIMIT && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] s3;
    logic [5:0]  b;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ready after reset", {31'b0, req_ready_o}, 32'd1);
    chk("R1 no response after reset", {31'b0, rsp_valid_o}, 32'd0);
    lookup(32'h0000_1234, 32'h0, 1'b1, 3, "R1 empty table faults");
    lookup(32'h3123_4567, 32'h0, 1'b1, 3, "R6 miss both buckets");

    s3 = 24'hABCDEF;
    seg_wr(4'd3, s3);
    // R2 R3 R4: primary hit, page 0x1234, bucket 0x1B
    b = pidx(s3, 16'h1234);
    chk("R3 index calc", {26'b0, b}, 32'h1B);
    tbl_wr(b, 2'd2, 1'b1, {s3, 16'h1234}, 20'h12345);
    lookup(32'h3123_4567, 32'h1234_5567, 1'b0, 2, "R4 primary hit");
    lookup(32'h3123_4FFF, 32'h1234_5FFF, 1'b0, 2, "R2 offset kept");

    // R5: secondary hit, page 0x0042, secondary bucket 0x12
    b = ~pidx(s3, 16'h0042);
    tbl_wr(b, 2'd0, 1'b1, {s3, 16'h0042}, 20'h0BEEF);
    lookup(32'h3004_2ABC, 32'h0BEE_FABC, 1'b0, 3, "R5 secondary hit");

    // R7: primary over secondary, then lower way over higher
    b = pidx(s3, 16'h0077);
    tbl_wr(~b, 2'd0, 1'b1, {s3, 16'h0077}, 20'h22222);
    tbl_wr(b, 2'd3, 1'b1, {s3, 16'h0077}, 20'h11111);
    lookup(32'h3007_7010, 32'h1111_1010, 1'b0, 2, "R7 primary priority");
    tbl_wr(b, 2'd1, 1'b1, {s3, 16'h0077}, 20'h33333);
    lookup(32'h3007_7020, 32'h3333_3020, 1'b0, 2, "R7 lowest way");

    // R11: same bucket, different upper segment bits
    seg_wr(4'd5, 24'h01ABEF);
    lookup(32'h5123_4567, 32'h0, 1'b1, 3, "R11 full tag compare");

    // R9: invalidate primary entry
    b = pidx(s3, 16'h1234);
    tbl_wr(b, 2'd2, 1'b0, {s3, 16'h1234}, 20'h12345);
    lookup(32'h3123_4567, 32'h0, 1'b1, 3, "R9 invalidated entry");

    // R10: segment change and entry overwrite
    tbl_wr(b, 2'd2, 1'b1, {24'h01ABEF, 16'h1234}, 20'h0AAAA);
    seg_wr(4'd3, 24'h01ABEF);
    lookup(32'h3123_4567, 32'h0AAA_A567, 1'b0, 2, "R10 new segment value");
    tbl_wr(b, 2'd2, 1'b1, {24'h01ABEF, 16'h1234}, 20'h0BBBB);
    lookup(32'h3123_4567, 32'h0BBB_B567, 1'b0, 2, "R10 entry overwrite");

    repeat (3) @(negedge clk_i);
    chk("R8 idle ready", {31'b0, req_ready_o}, 32'd1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule